// File: doc/BRIEF.md
# Multichannel Capture FIFO with DMA Drain

An eight-channel capture port feeds tagged 32-bit samples into a single shared FIFO of eight entries. Each entry holds the sample and the 3-bit number of the channel it came from. The FIFO is emptied in one of two ways. A DMA engine presents the head word on a valid/ready memory-write handshake and counts it against the remaining transfer count of its channel. Software can instead read the head word itself, prompted by a fill-level interrupt.

Software controls the block through level inputs and one-cycle strobes. These are a port enable, a global DMA enable, a mask of channels enabled for DMA, a 4-bit fill threshold, a per-channel count-load strobe with a shared load value, a write-1-to-clear strobe for the end-of-transfer flags, and a strobe that clears the overflow flags. Pausing DMA keeps the stored words. Disabling the port throws them away.

Top module: `capture_fifo_drain`

## Requirements
- R1: During reset and in the first cycle after it, mem_valid, thr_irq, done_irq, done_any and ovf_flag are all 0.
- R2: The FIFO holds up to 8 words and releases them in arrival order. head_data and head_ch show the oldest word whenever the FIFO is not empty. A word offered while the FIFO already holds 8 words is dropped, even if a pop happens in the same cycle.
- R3: When DMA mode is off, thr_irq is 1 exactly when the number of stored words is greater than thresh.
- R4: DMA mode is dma_en=1 together with at least one ch_dma_en bit set. In DMA mode thr_irq is 0.
- R5: mem_valid is 1 exactly when all of these hold: port_en=1, dma_en=1, the FIFO is not empty, the head word's channel has its ch_dma_en bit set, and that channel's remaining count is nonzero. A head word that is not eligible stalls the drain. The head word is popped when mem_valid and mem_ready are both 1.
- R6: Clearing dma_en stops the drain and leaves the stored words in place. Setting it again resumes from the same head word.
- R7: While port_en=0 the FIFO is empty and incoming words are ignored. Nothing is dropped and no overflow flag is set. After re-enabling, the FIFO fills from empty.
- R8: A cnt_load bit loads cnt_val into that channel's remaining count and clears its done flag; a load takes priority over everything else in the same cycle. Each DMA pop decrements the count of the head word's channel. The pop that takes a count from 1 to 0 sets done_irq for that channel. A done_clr bit clears that channel's done flag, but a flag set in the same cycle wins. done_any is the OR of done_irq.
- R9: A dropped word sets ovf_flag[its channel]. The flags are sticky until ovf_clr, which clears all of them. A drop in the same cycle as ovf_clr still sets its flag.
- R10: With port_en=1 and dma_en=0, cpu_rd pops the head word if the FIFO is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_en | input | 1 | Port enable; 0 flushes the FIFO |
| dma_en | input | 1 | Global DMA enable |
| ch_dma_en | input | 8 | Per-channel DMA enable |
| thresh | input | 4 | Fill threshold for thr_irq |
| cnt_load | input | 8 | Per-channel strobe that loads cnt_val |
| cnt_val | input | 16 | Transfer count to load |
| done_clr | input | 8 | Write-1-to-clear for done_irq |
| ovf_clr | input | 1 | Clears all overflow flags |
| in_valid | input | 1 | Incoming sample strobe |
| in_ch | input | 3 | Channel of the incoming sample |
| in_data | input | 32 | Incoming sample |
| cpu_rd | input | 1 | Manual pop of the head word |
| mem_valid | output | 1 | DMA write request |
| mem_ready | input | 1 | Memory accepts the write |
| head_data | output | 32 | Sample of the head word |
| head_ch | output | 3 | Channel of the head word |
| thr_irq | output | 1 | Fill-threshold interrupt |
| done_irq | output | 8 | Per-channel end-of-transfer flags |
| done_any | output | 1 | OR of done_irq |
| ovf_flag | output | 8 | Per-channel sticky overflow flags |

## Verification
On every cycle the assertions check four properties. The threshold interrupt stays silent in DMA mode. A stalled DMA request keeps its head word steady. A disabled port leaves no request and no interrupt behind it. The done and overflow flags never lose a bit without a clear or load. Word ordering, the exact drop point at the eighth entry, resuming after a pause, and the cycle in which a done flag appears can only be shown by the bench's scenarios, which compare every output against a cycle-accurate reference model.

// File: rtl/capture_fifo_drain.sv
module capture_fifo_drain #(
  parameter int W     = 32,
  parameter int NCH   = 8,
  parameter int DEPTH = 8,
  parameter int CNTW  = 16,
  parameter int THW   = 4,
  localparam int CHW  = $clog2(NCH),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            port_en,
  input  logic            dma_en,
  input  logic [NCH-1:0]  ch_dma_en,
  input  logic [THW-1:0]  thresh,
  input  logic [NCH-1:0]  cnt_load,
  input  logic [CNTW-1:0] cnt_val,
  input  logic [NCH-1:0]  done_clr,
  input  logic            ovf_clr,
  input  logic            in_valid,
  input  logic [CHW-1:0]  in_ch,
  input  logic [W-1:0]    in_data,
  input  logic            cpu_rd,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic [W-1:0]    head_data,
  output logic [CHW-1:0]  head_ch,
  output logic            thr_irq,
  output logic [NCH-1:0]  done_irq,
  output logic            done_any,
  output logic [NCH-1:0]  ovf_flag
);

  logic [W-1:0]    dmem [DEPTH];
  logic [CHW-1:0]  cmem [DEPTH];
  logic [PW-1:0]   wp, rp;
  logic [PW:0]     cnt;
  logic [CNTW-1:0] rem [NCH];

  wire nonempty = cnt != '0;
  wire full     = cnt == (PW+1)'(DEPTH);
  wire dma_mode = dma_en & |ch_dma_en;
  wire push     = in_valid & port_en & ~full;
  wire drop     = in_valid & port_en & full;
  wire pop_dma  = mem_valid & mem_ready;
  wire pop_cpu  = cpu_rd & port_en & ~dma_en & nonempty;
  wire pop      = pop_dma | pop_cpu;

  assign head_data = dmem[rp];
  assign head_ch   = cmem[rp];
  assign mem_valid = port_en & dma_en & nonempty & ch_dma_en[head_ch] & (rem[head_ch] != '0);
  assign thr_irq   = ~dma_mode & (cnt > (PW+1)'(thresh));
  assign done_any  = |done_irq;

  always_ff @(posedge clk) begin
    if (push) begin
      dmem[wp] <= in_data;
      cmem[wp] <= in_ch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (!port_en) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + (PW+1)'(push) - (PW+1)'(pop);
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire hit = pop_dma & (head_ch == CHW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rem[i]      <= '0;
        done_irq[i] <= 1'b0;
      end else if (cnt_load[i]) begin
        rem[i]      <= cnt_val;
        done_irq[i] <= 1'b0;
      end else begin
        if (hit) rem[i] <= rem[i] - 1'b1;
        if (hit && rem[i] == CNTW'(1)) done_irq[i] <= 1'b1;
        else if (done_clr[i])          done_irq[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_flag <= '0;
    else        ovf_flag <= (ovf_clr ? '0 : ovf_flag) | (drop ? NCH'(1) << in_ch : '0);
  end

endmodule

// File: rtl/capture_fifo_drain_chk.sv
module capture_fifo_drain_chk #(
  parameter int W   = 32,
  parameter int NCH = 8,
  parameter int CHW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           port_en,
  input logic           dma_en,
  input logic [NCH-1:0] ch_dma_en,
  input logic [NCH-1:0] cnt_load,
  input logic [NCH-1:0] done_clr,
  input logic           ovf_clr,
  input logic           in_valid,
  input logic           mem_valid,
  input logic           mem_ready,
  input logic [W-1:0]   head_data,
  input logic [CHW-1:0] head_ch,
  input logic           thr_irq,
  input logic [NCH-1:0] done_irq,
  input logic [NCH-1:0] ovf_flag
);

  AST_THR_QUIET_IN_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && |ch_dma_en) |-> !thr_irq); // R4

  AST_REQ_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (port_en && dma_en)); // R5

  AST_STALL_HOLDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && port_en) |=> ($stable(head_data) && $stable(head_ch))); // R5

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (!mem_valid && !thr_irq)); // R7

  AST_OVF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !in_valid) |=> (ovf_flag == '0)); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_clr |=> ((ovf_flag & $past(ovf_flag)) == $past(ovf_flag))); // R9

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr == '0 && cnt_load == '0) |=> ((done_irq & $past(done_irq)) == $past(done_irq))); // R8

endmodule

bind capture_fifo_drain capture_fifo_drain_chk #(.W(W), .NCH(NCH), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .dma_en(dma_en), .ch_dma_en(ch_dma_en),
  .cnt_load(cnt_load), .done_clr(done_clr), .ovf_clr(ovf_clr), .in_valid(in_valid),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .head_data(head_data), .head_ch(head_ch),
  .thr_irq(thr_irq), .done_irq(done_irq), .ovf_flag(ovf_flag)
);

// File: tb/tb_capture_fifo_drain.sv
module tb_capture_fifo_drain;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic port_en = 0, dma_en = 0, ovf_clr = 0, in_valid = 0, cpu_rd = 0, mem_ready = 0;
  logic [7:0] ch_dma_en = 0, cnt_load = 0, done_clr = 0;
  logic [3:0] thresh = 0;
  logic [15:0] cnt_val = 0;
  logic [2:0] in_ch = 0;
  logic [31:0] in_data = 0;
  logic mem_valid, thr_irq, done_any;
  logic [31:0] head_data;
  logic [2:0] head_ch;
  logic [7:0] done_irq, ovf_flag;

  int checks = 0, errors = 0;
  logic [31:0] md [8];
  logic [2:0]  mc [8];
  int          mcnt = 0;
  int          mrem [8];
  logic [7:0]  mdone = 0, movf = 0;

  always #(PERIOD/2) clk = ~clk;

  capture_fifo_drain dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .dma_en(dma_en), .ch_dma_en(ch_dma_en),
    .thresh(thresh), .cnt_load(cnt_load), .cnt_val(cnt_val), .done_clr(done_clr),
    .ovf_clr(ovf_clr), .in_valid(in_valid), .in_ch(in_ch), .in_data(in_data),
    .cpu_rd(cpu_rd), .mem_valid(mem_valid), .mem_ready(mem_ready), .head_data(head_data),
    .head_ch(head_ch), .thr_irq(thr_irq), .done_irq(done_irq), .done_any(done_any),
    .ovf_flag(ovf_flag)
  );

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit exp_valid();
    return port_en && dma_en && mcnt > 0 && ch_dma_en[mc[0]] && mrem[mc[0]] != 0;
  endfunction

  function automatic bit exp_thr();
    return !(dma_en && |ch_dma_en) && mcnt > int'(thresh);
  endfunction

  task automatic strobes_off();
    cnt_load = 0; done_clr = 0; ovf_clr = 0; in_valid = 0; cpu_rd = 0;
  endtask

  // inputs already driven after a negedge: compare, advance the model, move to next negedge
  task automatic step();
    bit v, pdma, pop, push, drop;
    logic [2:0] h;
    logic [7:0] dn;
    #1;
    v = exp_valid();
    check("R5 mem_valid", mem_valid, v);
    check((dma_en && |ch_dma_en) ? "R4 thr_irq" : "R3 thr_irq", thr_irq, exp_thr());
    if (mcnt > 0) begin
      check("R2 head_data", head_data, md[0]);
      check("R2 head_ch", head_ch, mc[0]);
    end
    check("R8 done_irq", done_irq, mdone);
    check("R8 done_any", done_any, |mdone);
    check("R9 ovf_flag", ovf_flag, movf);
    h    = mc[0];
    pdma = v && mem_ready;
    pop  = pdma || (cpu_rd && port_en && !dma_en && mcnt > 0); // R10
    push = in_valid && port_en && mcnt < 8;
    drop = in_valid && port_en && mcnt == 8;
    dn = mdone & ~done_clr;
    if (pdma) begin
      if (mrem[h] == 1) dn[h] = 1'b1;
      mrem[h]--;
    end
    for (int i = 0; i < 8; i++) if (cnt_load[i]) begin mrem[i] = cnt_val; dn[i] = 1'b0; end
    mdone = dn;
    if (ovf_clr) movf = 0;
    if (drop) movf[in_ch] = 1'b1;
    if (!port_en) mcnt = 0; // R7
    else begin
      if (pop) begin
        for (int i = 0; i < 7; i++) begin md[i] = md[i+1]; mc[i] = mc[i+1]; end
        mcnt--;
      end
      if (push) begin md[mcnt] = in_data; mc[mcnt] = in_ch; mcnt++; end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push_word(logic [2:0] ch, logic [31:0] d);
    strobes_off(); in_valid = 1; in_ch = ch; in_data = d; step();
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) mrem[i] = 0;
    #(PERIOD * 2 + 1);
    check("R1 mem_valid", mem_valid, 0);
    check("R1 done_any", done_any, 0);
    check("R1 ovf_flag", ovf_flag, 0);
    @(negedge clk); rst_n = 1;
    step(); // R1 first cycle after reset

    // R2/R3/R9: fill past full with the port on and DMA off
    port_en = 1; thresh = 4'd3;
    for (int i = 0; i < 10; i++) push_word(3'(i), 32'hA000_0000 + 32'(i));
    // R9: clear overflow, then drop in the clear cycle
    strobes_off(); ovf_clr = 1; step();
    strobes_off(); ovf_clr = 1; in_valid = 1; in_ch = 3'd5; in_data = 32'h55; step();
    // R10: manual reads drain a few words
    for (int i = 0; i < 3; i++) begin strobes_off(); cpu_rd = 1; step(); end
    // R8: load counts and drain by DMA; R4 suppresses thr_irq
    strobes_off(); cnt_load = 8'hFF; cnt_val = 16'd1; step();
    strobes_off(); dma_en = 1; ch_dma_en = 8'hFF; mem_ready = 1; step();
    // R6: pause keeps contents, resume continues
    strobes_off(); dma_en = 0; step(); step();
    strobes_off(); dma_en = 1; step();
    // R5: channel with zero count stalls, reload unstalls
    mem_ready = 1; for (int i = 0; i < 4; i++) begin strobes_off(); step(); end
    push_word(3'd2, 32'hBEEF); push_word(3'd2, 32'hCAFE);
    strobes_off(); step();
    strobes_off(); cnt_load = 8'h04; cnt_val = 16'd2; step();
    strobes_off(); done_clr = 8'h04; step(); step(); step();
    // R7: flush and ignored input
    push_word(3'd1, 32'h1111);
    strobes_off(); port_en = 0; step();
    strobes_off(); in_valid = 1; in_ch = 3'd6; step();
    strobes_off(); port_en = 1; step();

    // constrained random mix
    for (int seg = 0; seg < 12; seg++) begin
      for (int c = 0; c < 400; c++) begin
        strobes_off();
        port_en   = ($urandom_range(0, 99) >= ((seg % 4 == 3) ? 10 : 1));
        if ($urandom_range(0, 29) == 0) dma_en = ~dma_en;
        if ($urandom_range(0, 49) == 0) ch_dma_en = (seg % 3 == 0) ? 8'($urandom()) : 8'hFF;
        if ($urandom_range(0, 99) == 0) thresh = 4'($urandom());
        in_valid  = ($urandom_range(0, 99) < ((seg % 2) ? 70 : 35));
        in_ch     = 3'($urandom());
        in_data   = $urandom();
        mem_ready = ($urandom_range(0, 99) < 60);
        cpu_rd    = ($urandom_range(0, 3) == 0);
        if ($urandom_range(0, 9) == 0) begin cnt_load = 8'($urandom()); cnt_val = 16'($urandom_range(0, 5)); end
        if ($urandom_range(0, 7) == 0) done_clr = 8'($urandom());
        ovf_clr   = ($urandom_range(0, 39) == 0);
        step();
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule